// File: doc/BRIEF.md
# Slot Table Schedule Builder

This block builds the 64-entry access schedule that a memory arbiter walks for one memory region. Each of the 14 clients arrives with a precomputed slot count. The block spreads each client's slots evenly across the table at a fixed stride. Clients that request nothing but are marked active get one slot each while a budget of spare slots lasts. Every slot still empty after that goes to the active clients in turn. The finished table is written out one slot per cycle, in index order, over a simple write port.

A start pulse takes a snapshot of the request counts, the active vector and the spare-slot budget, then runs the build to completion. Beside the build engine sits a combinational admission check. It compares the live request counts plus a candidate new request against the table size, so control logic can refuse a request before committing it.

The engine steps through a fixed sequence of states. `S_IDLE` waits for start and takes the snapshot (IDLE→SELECT). `S_SELECT` decides whether the current client places anything: it goes SELECT→WALK to place, SELECT→SELECT to move to the next client, or SELECT→FILL after the last client. `S_WALK` advances the placement position by one step per cycle, going WALK→SELECT or WALK→FILL once the position passes the table end. `S_FILL` settles and emits one slot per cycle (FILL→DONE after slot 63). `S_DONE` raises done for one cycle (DONE→IDLE).

Top module: `slot_sched_top`

## Requirements
- R1: After reset, busy, wr_en and done are all 0.
- R2: A start pulse in idle captures req_cnt_flat, active and budget. Changes to those inputs after the capture cycle do not alter the table being built.
- R3: Clients are placed in ascending ID order, and each client's request occupies bits [7c+6:7c] of req_cnt_flat. For a request N in 1..64 the stride is 64/N, rounded down. Placement starts at position 0. An occupied position advances the position by 1. A free position receives the client ID and advances the position by the stride. Placement stops once the position is 64 or more. Placement takes place whether or not the client is active.
- R4: A client with request 0 whose active bit is 1 makes one stride-64 placement, landing on the first free slot from 0, but only while the remaining budget is above 0. Each such placement lowers the budget by 1. A client with request 0 whose active bit is 0 places nothing.
- R5: After placement, empty slots are settled in ascending index order. A rotating pointer starts at client 0. Each empty slot goes to the first client with active=1, searching from the pointer upward with wraparound, and the pointer then moves to that client plus 1, modulo 14.
- R6: When no client is active, an empty slot goes to the pointer's own client, so the empty slots cycle through IDs 0..13.
- R7: A build emits exactly 64 writes on consecutive cycles. wr_idx runs from 0 to 63 and wr_client is always below 14.
- R8: done is high for exactly one cycle, in the cycle right after the write to slot 63. In the following cycle busy is 0.
- R9: admit_ok is 1 exactly when the sum of the 14 live request counts plus new_req is at most 64. The check is combinational and valid in every state.
- R10: A start pulse while busy is ignored. The running build continues its write sequence unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a build (sampled in idle only) |
| req_cnt_flat | input | 98 | 14 requested slot counts, 7 bits each, client c at [7c+6:7c] |
| active | input | 14 | Active-client vector, bit c for client c |
| budget | input | 7 | Spare slots available to active zero-request clients |
| new_req | input | 7 | Candidate request for the admission check |
| admit_ok | output | 1 | Candidate request fits in the table |
| busy | output | 1 | Build in progress, including the done cycle |
| wr_en | output | 1 | Slot write strobe |
| wr_idx | output | 6 | Slot index being written |
| wr_client | output | 4 | Client ID for that slot |
| done | output | 1 | One-cycle completion pulse |

## Verification
The admission check and the build engine can act in the same cycle. The check reads the live request inputs, while the build works from its captured copy of them. To provoke the overlap, the bench overwrites every request, active and budget input right after start, and it probes admit_ok against the new values while the slot writes are still coming out. The emitted table must match the one expected from the captured values, and admit_ok must follow the new ones. A second overlap, a start pulse held during the write phase, is judged by checking that the write sequence and the table stay unchanged.

// File: rtl/slot_sched_pkg.sv
package slot_sched_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SELECT,
        S_WALK,
        S_FILL,
        S_DONE
    } sched_state_e;

endpackage

// File: rtl/slot_sched_stride.sv
// Stride for one client: table size divided by its request.
// A zero request yields a full-table stride (single placement).
module slot_sched_stride #(
    parameter int NUM_SLOTS = 64,
    parameter int CNT_W     = 7,
    parameter int POS_W     = 8
) (
    input  logic [CNT_W-1:0] req,
    output logic [POS_W-1:0] stride
);
    localparam logic [POS_W-1:0] SLOTS_V = POS_W'(NUM_SLOTS);

    logic [POS_W-1:0] quot;

    always_comb begin
        quot = '0;
        if (req == '0) begin
            stride = SLOTS_V;
        end else begin
            quot   = SLOTS_V / POS_W'(req);
            stride = (quot == '0) ? POS_W'(1) : quot;
        end
    end
endmodule

// File: rtl/slot_sched_rr_pick.sv
// Rotating search for the next active client starting at ptr.
// With no active client the pointer's own client is returned.
module slot_sched_rr_pick #(
    parameter int NUM_CLIENTS = 14,
    parameter int CID_W       = 4
) (
    input  logic [NUM_CLIENTS-1:0] active,
    input  logic [CID_W-1:0]       ptr,
    output logic [CID_W-1:0]       pick,
    output logic [CID_W-1:0]       next_ptr
);
    logic found;

    always_comb begin
        pick  = ptr;
        found = 1'b0;
        for (int k = 0; k < NUM_CLIENTS; k++) begin
            int cand;
            cand = int'(ptr) + k;
            if (cand >= NUM_CLIENTS) cand = cand - NUM_CLIENTS;
            if (!found && active[cand]) begin
                pick  = CID_W'(cand);
                found = 1'b1;
            end
        end
        next_ptr = (pick == CID_W'(NUM_CLIENTS - 1)) ? '0 : pick + 1'b1;
    end
endmodule

// File: rtl/slot_sched_admit.sv
// Admission: accepted when the sum of live requests plus the candidate
// does not exceed the table size.
module slot_sched_admit #(
    parameter int NUM_SLOTS   = 64,
    parameter int NUM_CLIENTS = 14,
    parameter int CNT_W       = 7
) (
    input  logic [NUM_CLIENTS*CNT_W-1:0] req_flat,
    input  logic [CNT_W-1:0]             new_req,
    output logic                         admit_ok
);
    localparam int SUM_W = CNT_W + $clog2(NUM_CLIENTS + 1) + 1;

    logic [SUM_W-1:0] total;

    always_comb begin
        total = SUM_W'(new_req);
        for (int c = 0; c < NUM_CLIENTS; c++) begin
            total = total + SUM_W'(req_flat[c*CNT_W +: CNT_W]);
        end
        admit_ok = (total <= SUM_W'(NUM_SLOTS));
    end
endmodule

// File: rtl/slot_sched_top.sv
module slot_sched_top
    import slot_sched_pkg::*;
#(
    parameter int NUM_SLOTS   = 64,
    parameter int NUM_CLIENTS = 14,
    parameter int CNT_W       = $clog2(NUM_SLOTS) + 1,
    parameter int IDX_W       = $clog2(NUM_SLOTS),
    parameter int CID_W       = $clog2(NUM_CLIENTS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [NUM_CLIENTS*CNT_W-1:0] req_cnt_flat,
    input  logic [NUM_CLIENTS-1:0]       active,
    input  logic [CNT_W-1:0]             budget,
    input  logic [CNT_W-1:0]             new_req,
    output logic                         admit_ok,
    output logic                         busy,
    output logic                         wr_en,
    output logic [IDX_W-1:0]             wr_idx,
    output logic [CID_W-1:0]             wr_client,
    output logic                         done
);
    localparam int POS_W = CNT_W + 1;
    localparam logic [POS_W-1:0] END_POS = POS_W'(NUM_SLOTS);
    localparam logic [CID_W-1:0] LAST_CL = CID_W'(NUM_CLIENTS - 1);
    localparam logic [IDX_W-1:0] LAST_IX = IDX_W'(NUM_SLOTS - 1);

    sched_state_e state, state_nx;

    logic [NUM_CLIENTS*CNT_W-1:0] req_q;
    logic [NUM_CLIENTS-1:0]       act_q;
    logic [CNT_W-1:0]             budget_q;
    logic [NUM_SLOTS-1:0]         occ;
    logic [CID_W-1:0]             tbl [NUM_SLOTS];
    logic [CID_W-1:0]             cl;
    logic [POS_W-1:0]             pos;
    logic [POS_W-1:0]             stride_q;
    logic [IDX_W-1:0]             idx;
    logic [CID_W-1:0]             ptr;

    logic [CNT_W-1:0] req_cur;
    logic [POS_W-1:0] stride_w;
    logic [CID_W-1:0] pick, next_ptr;
    logic             place_now, last_client, pos_in;
    logic [IDX_W-1:0] pos_idx;

    assign req_cur     = req_q[cl*CNT_W +: CNT_W];
    assign place_now   = (req_cur != '0) || (act_q[cl] && (budget_q != '0));
    assign last_client = (cl == LAST_CL);
    assign pos_in      = (pos < END_POS);
    assign pos_idx     = pos[IDX_W-1:0];

    slot_sched_stride #(
        .NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W), .POS_W(POS_W)
    ) u_stride (
        .req(req_cur), .stride(stride_w)
    );

    slot_sched_rr_pick #(
        .NUM_CLIENTS(NUM_CLIENTS), .CID_W(CID_W)
    ) u_pick (
        .active(act_q), .ptr(ptr), .pick(pick), .next_ptr(next_ptr)
    );

    slot_sched_admit #(
        .NUM_SLOTS(NUM_SLOTS), .NUM_CLIENTS(NUM_CLIENTS), .CNT_W(CNT_W)
    ) u_admit (
        .req_flat(req_cnt_flat), .new_req(new_req), .admit_ok(admit_ok)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (start) state_nx = S_SELECT;
            S_SELECT: begin
                if (place_now)        state_nx = S_WALK;
                else if (last_client) state_nx = S_FILL;
            end
            S_WALK:   if (!pos_in) state_nx = last_client ? S_FILL : S_SELECT;
            S_FILL:   if (idx == LAST_IX) state_nx = S_DONE;
            S_DONE:   state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q    <= '0;
            act_q    <= '0;
            budget_q <= '0;
            occ      <= '0;
            cl       <= '0;
            pos      <= '0;
            stride_q <= '0;
            idx      <= '0;
            ptr      <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        req_q    <= req_cnt_flat;
                        act_q    <= active;
                        budget_q <= budget;
                        occ      <= '0;
                        cl       <= '0;
                    end
                end
                S_SELECT: begin
                    if (place_now) begin
                        pos      <= '0;
                        stride_q <= stride_w;
                        if (req_cur == '0) budget_q <= budget_q - 1'b1;
                    end else if (!last_client) begin
                        cl <= cl + 1'b1;
                    end else begin
                        idx <= '0;
                        ptr <= '0;
                    end
                end
                S_WALK: begin
                    if (!pos_in) begin
                        if (!last_client) begin
                            cl <= cl + 1'b1;
                        end else begin
                            idx <= '0;
                            ptr <= '0;
                        end
                    end else if (occ[pos_idx]) begin
                        pos <= pos + 1'b1;
                    end else begin
                        occ[pos_idx] <= 1'b1;
                        pos          <= pos + stride_q;
                    end
                end
                S_FILL: begin
                    if (!occ[idx]) ptr <= next_ptr;
                    idx <= idx + 1'b1;
                end
                S_DONE: ;
                default: ;
            endcase
        end
    end

    // Slot value storage (no reset needed: qualified by occ)
    always_ff @(posedge clk) begin
        if (state == S_WALK && pos_in && !occ[pos_idx]) tbl[pos_idx] <= cl;
    end

    // Outputs
    always_comb begin
        busy      = (state != S_IDLE);
        wr_en     = (state == S_FILL);
        done      = (state == S_DONE);
        wr_idx    = idx;
        wr_client = occ[idx] ? tbl[idx] : pick;
    end
endmodule

// File: rtl/slot_sched_chk.sv
module slot_sched_chk #(
    parameter int NUM_SLOTS   = 64,
    parameter int NUM_CLIENTS = 14,
    parameter int IDX_W       = 6,
    parameter int CID_W       = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             wr_en,
    input logic [IDX_W-1:0] wr_idx,
    input logic [CID_W-1:0] wr_client,
    input logic             done
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en || done) |-> busy);

    // R7
    first_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !$past(wr_en)) |-> (wr_idx == '0));

    // R7
    write_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (wr_idx == IDX_W'($past(wr_idx) + 1'b1)));

    // R7
    client_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_client < CID_W'(NUM_CLIENTS)));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(wr_en) && ($past(wr_idx) == IDX_W'(NUM_SLOTS - 1))));

    // R10
    restart_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && start && (wr_idx != IDX_W'(NUM_SLOTS - 1)))
            |=> (wr_en && (wr_idx == IDX_W'($past(wr_idx) + 1'b1))));
endmodule

bind slot_sched_top slot_sched_chk #(
    .NUM_SLOTS(NUM_SLOTS), .NUM_CLIENTS(NUM_CLIENTS),
    .IDX_W(IDX_W), .CID_W(CID_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_client(wr_client), .done(done)
);

// File: tb/slot_sched_top_tb.sv
module slot_sched_top_tb;
    localparam int NS = 64;
    localparam int NC = 14;
    localparam int CW = 7;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [NC*CW-1:0] req_cnt_flat = '0;
    logic [NC-1:0]  active = '0;
    logic [CW-1:0]  budget = '0;
    logic [CW-1:0]  new_req = '0;
    logic           admit_ok, busy, wr_en, done;
    logic [5:0]     wr_idx;
    logic [3:0]     wr_client;

    slot_sched_top u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .req_cnt_flat(req_cnt_flat),
        .active(active), .budget(budget), .new_req(new_req),
        .admit_ok(admit_ok), .busy(busy), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_client(wr_client), .done(done)
    );

    always #4 clk = ~clk;  // 125 MHz

    int n_chk = 0;
    int n_fail = 0;
    int cyc_all = 0;

    int req_m [NC];
    int act_m [NC];
    int bud_m;
    int exp_t [NS];

    always @(posedge clk) begin
        cyc_all++;
        if (cyc_all > 190000) begin
            n_fail++;
            $display("FAIL watchdog: cycles %0d expected below %0d", cyc_all, 190000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected table straight from R3..R6
    task automatic model();
        int bud;
        int ptr;
        bud = bud_m;
        for (int s = 0; s < NS; s++) exp_t[s] = -1;
        for (int c = 0; c < NC; c++) begin
            int stp;
            int p;
            if (req_m[c] == 0) begin
                if (act_m[c] == 0 || bud <= 0) continue;
                bud--;
                stp = NS;
            end else begin
                stp = NS / req_m[c];
            end
            p = 0;
            while (p < NS) begin
                if (exp_t[p] >= 0) p++;
                else begin
                    exp_t[p] = c;
                    p += stp;
                end
            end
        end
        ptr = 0;
        for (int s = 0; s < NS; s++) begin
            if (exp_t[s] < 0) begin
                int first;
                first = ptr;
                while (act_m[ptr] == 0) begin
                    ptr = (ptr + 1) % NC;
                    if (ptr == first) break;
                end
                exp_t[s] = ptr;
                ptr = (ptr + 1) % NC;
            end
        end
    endtask

    task automatic drive_inputs();
        for (int c = 0; c < NC; c++) begin
            req_cnt_flat[c*CW +: CW] = CW'(req_m[c]);
            active[c] = act_m[c][0];
        end
        budget = CW'(bud_m);
    endtask

    task automatic run_build(input string tag, input bit scramble, input bit restart);
        int got [NS];
        int wcnt;
        int nxt;
        int cyc;
        int bad;
        bit order_ok;
        bit seen_done;
        wcnt = 0; nxt = 0; cyc = 0; bad = 0; order_ok = 1'b1; seen_done = 1'b0;
        for (int s = 0; s < NS; s++) got[s] = -1;
        model();
        @(negedge clk);
        drive_inputs();
        start = 1'b1;
        @(negedge clk);
        start = restart;
        if (scramble) begin
            // R2: new inputs after capture; admission follows the live values
            req_cnt_flat = '0;
            req_cnt_flat[CW-1:0] = 7'd60;
            active = ~active;
            budget = 7'd99;
            new_req = 7'd4;
            #1 chk(admit_ok == 1'b1, "R9 live during build", admit_ok, 1);
            new_req = 7'd5;
            #1 chk(admit_ok == 1'b0, "R9 live during build", admit_ok, 0);
        end
        while (!seen_done && cyc < 3000) begin
            @(negedge clk);
            cyc++;
            if (wr_en) begin
                if (int'(wr_idx) != nxt) order_ok = 1'b0;
                got[wr_idx] = int'(wr_client);
                nxt++;
                wcnt++;
                if (restart && wr_idx >= 6'd60) start = 1'b0;
            end
            if (done) seen_done = 1'b1;
        end
        start = 1'b0;
        chk(seen_done, {tag, " R8 done seen"}, seen_done, 1);
        chk(wcnt == NS, {tag, " R7 write count"}, wcnt, NS);
        chk(order_ok, {tag, " R7 write order"}, order_ok, 1);
        for (int s = 0; s < NS; s++) begin
            if (got[s] != exp_t[s]) begin
                bad++;
                $display("FAIL %s slot %0d: got %0d expected %0d", tag, s, got[s], exp_t[s]);
            end
        end
        n_chk++;
        if (bad != 0) n_fail++;
        @(negedge clk);
        chk(done == 1'b0, {tag, " R8 done single cycle"}, done, 0);
        chk(busy == 1'b0, {tag, " R8 idle after done"}, busy, 0);
    endtask

    task automatic clear_cfg();
        for (int c = 0; c < NC; c++) begin
            req_m[c] = 0;
            act_m[c] = 0;
        end
        bud_m = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R1 busy in reset", busy, 0);
        chk(wr_en == 1'b0, "R1 wr_en in reset", wr_en, 0);
        chk(done == 1'b0, "R1 done in reset", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R1 busy after reset", busy, 0);

        // R6: nothing requested, nobody active
        clear_cfg();
        run_build("R6 none active", 1'b0, 1'b0);

        // R3: single-client sweep over every request size
        for (int n = 1; n <= NS; n++) begin
            clear_cfg();
            req_m[n % NC] = n;
            for (int c = 0; c < NC; c++) act_m[c] = (c % 3 == 1) ? 1 : 0;
            bud_m = 2;
            run_build("R3 single sweep", 1'b0, 1'b0);
        end

        // R3: several nested strides, inactive requesters still placed
        clear_cfg();
        req_m[0] = 32; req_m[1] = 16; req_m[2] = 8; req_m[5] = 7; req_m[9] = 1;
        act_m[3] = 1; act_m[12] = 1;
        run_build("R3 multi stride", 1'b0, 1'b0);

        // R4: all active, zero requests, budget limits single placements
        for (int b = 0; b <= 15; b++) begin
            clear_cfg();
            for (int c = 0; c < NC; c++) act_m[c] = 1;
            bud_m = b;
            run_build("R4 budget sweep", 1'b0, 1'b0);
        end

        // R4/R5: mix of requesters, zero-request actives, sparse actives
        clear_cfg();
        req_m[4] = 3; req_m[7] = 10;
        act_m[0] = 1; act_m[6] = 1; act_m[13] = 1;
        bud_m = 1;
        run_build("R5 sparse active", 1'b0, 1'b0);

        // R5: random configurations
        for (int t = 0; t < 40; t++) begin
            clear_cfg();
            for (int c = 0; c < NC; c++) begin
                req_m[c] = ($urandom_range(0, 1) == 0) ? 0 : int'($urandom_range(1, 12));
                act_m[c] = int'($urandom_range(0, 1));
            end
            bud_m = int'($urandom_range(0, 5));
            run_build("R5 random", 1'b0, 1'b0);
        end

        // R2: inputs overwritten right after start
        clear_cfg();
        req_m[2] = 5; req_m[11] = 20;
        act_m[1] = 1; act_m[8] = 1;
        bud_m = 1;
        run_build("R2 snapshot", 1'b1, 1'b0);

        // R10: start held high during the build
        clear_cfg();
        req_m[3] = 9;
        act_m[3] = 1; act_m[10] = 1;
        run_build("R10 restart ignored", 1'b0, 1'b1);

        // R9: admission boundary sweeps
        for (int t = 0; t < 6; t++) begin
            int sum;
            sum = 0;
            for (int c = 0; c < NC; c++) begin
                int v;
                v = (t == 0) ? 0 : int'($urandom_range(0, 6));
                req_cnt_flat[c*CW +: CW] = CW'(v);
                sum += v;
            end
            for (int nr = 0; nr <= 70; nr++) begin
                new_req = CW'(nr);
                #1;
                chk(admit_ok == ((sum + nr) <= NS), "R9 admission", admit_ok,
                    ((sum + nr) <= NS) ? 1 : 0);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule